// File: doc/BRIEF.md
# Broadcast-Distribute-Join Tile Router

This block sits between the operand streams of a matrix-vector product and a set of identical compute lanes. The number of lanes is a parameter, at most one per hardware column. One input stream carries vector elements and another carries matrix elements. Every vector beat is broadcast to all lanes. Matrix beats are handed out in blocks, and each block goes to a single lane. A block is the row of square tiles (`CHUNK`×`CHUNK` each) that produces one output chunk. The lanes return result chunks of `CHUNK` elements, and the router merges them into one ordered output stream.

With the default sizes (a 288×288 matrix, 32-element chunks, one vector column) each result vector is made of nine chunks. Lanes are reused round-robin, so a lane usually computes several chunks of one result. Every stream uses a valid/ready handshake. The router marks the end of each complete result vector with a one-cycle pulse. Lane arithmetic and memory are outside the block.

Top module: `tile_fanout_router`

## Requirements
- R1: While reset is held, with all input valids low, no lane sees a valid vector or matrix beat, `resValid` is low and `done` is low.
- R2: Each vector beat is presented to every lane with unchanged data, and every lane receives each vector beat exactly once and in stream order.
- R3: `vecReady` is high only when every lane has accepted the current vector beat, either in an earlier cycle or in this one. A lane that has already accepted the current beat sees its `laneVecValid` low until the beat completes upstream.
- R4: Matrix beats go out in blocks of `CHUNK*CHUNK*(MAT_DIM/CHUNK)` beats, and each block goes to exactly one lane. Blocks are assigned to lanes 0, 1, 2 and so on, wrapping after lane `NUM_LANES-1`.
- R5: After `MAT_DIM/CHUNK` blocks (one full matrix), the next block goes to lane 0 again.
- R6: At most one lane sees `laneMatValid` at a time. While `matValid` is high, `matReady` equals the `laneMatReady` of the selected lane.
- R7: The joined output takes `CHUNK` beats from one lane and then moves to the next lane, following the same lane order as the matrix blocks and restarting at lane 0 for each result. Data passes through unchanged, and at most one lane sees `laneResReady`.
- R8: `done` is high for exactly the one cycle after the last beat of the `MAT_DIM/CHUNK`-th chunk of a result is accepted at the output, and it is low at all other times.
- R9: `resValid` follows only the currently selected lane. The valid signals and data of the other lanes have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vecData | input | DATA_W | Vector element |
| vecValid | input | 1 | Vector element valid |
| vecReady | output | 1 | Vector element accepted by all lanes |
| matData | input | DATA_W | Matrix element |
| matValid | input | 1 | Matrix element valid |
| matReady | output | 1 | Matrix element accepted |
| laneVecData | output | DATA_W | Broadcast vector element |
| laneVecValid | output | NUM_LANES | Per-lane vector valid |
| laneVecReady | input | NUM_LANES | Per-lane vector ready |
| laneMatData | output | DATA_W | Distributed matrix element |
| laneMatValid | output | NUM_LANES | Per-lane matrix valid |
| laneMatReady | input | NUM_LANES | Per-lane matrix ready |
| laneResData | input | NUM_LANES*RES_W | Per-lane result element, lane i in bits i*RES_W upward |
| laneResValid | input | NUM_LANES | Per-lane result valid |
| laneResReady | output | NUM_LANES | Per-lane result ready |
| resData | output | RES_W | Joined result element |
| resValid | output | 1 | Joined result valid |
| resReady | input | 1 | Joined result ready |
| done | output | 1 | One-cycle pulse after the final beat of a result |

## Verification
A broadcast flag that is stuck or cleared too early shows up at once: a lane receives a beat twice, or the upstream beat completes while a lane still holds it back. A wrong beat, block or lane counter gives a lane matrix data out of order at the next block edge, which comes at most `CHUNK*CHUNK*(MAT_DIM/CHUNK)` beats later. A join counter that is off by one makes the output switch to the wrong lane within one chunk, and it shifts the `done` pulse by the same number of beats.

// File: rtl/tile_router_pkg.sv
package tile_router_pkg;
  localparam int SEL_W = 8;
  typedef logic [SEL_W-1:0] laneSel_t;

  // strobes from control to datapath
  typedef struct packed {
    laneSel_t matLane;
    laneSel_t resLane;
  } routeCtl_t;

  // handshake events from datapath to control
  typedef struct packed {
    logic matFire;
    logic resFire;
  } routeEvt_t;
endpackage

// File: rtl/tfr_ctrl.sv
module tfr_ctrl
  import tile_router_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CHUNK     = 32,
  parameter int MAT_DIM   = 288
) (
  input  logic      clk,
  input  logic      rstN,
  input  routeEvt_t evt,
  output routeCtl_t ctl,
  output logic      doneOut
);
  localparam int ROW_BLOCKS  = MAT_DIM / CHUNK;
  localparam int BLOCK_BEATS = CHUNK * CHUNK * ROW_BLOCKS;
  localparam int BEAT_W  = (BLOCK_BEATS > 1) ? $clog2(BLOCK_BEATS) : 1;
  localparam int BLK_W   = (ROW_BLOCKS > 1) ? $clog2(ROW_BLOCKS) : 1;
  localparam int CBEAT_W = (CHUNK > 1) ? $clog2(CHUNK) : 1;

  laneSel_t           matLane, resLane;
  logic [BEAT_W-1:0]  matBeat;
  logic [BLK_W-1:0]   matBlock, resChunk;
  logic [CBEAT_W-1:0] resBeat;
  logic               doneR;

  logic matBlockEnd, matMatrixEnd, resChunkEnd, resVecEnd;
  assign matBlockEnd  = (matBeat == BEAT_W'(BLOCK_BEATS - 1));
  assign matMatrixEnd = matBlockEnd && (matBlock == BLK_W'(ROW_BLOCKS - 1));
  assign resChunkEnd  = (resBeat == CBEAT_W'(CHUNK - 1));
  assign resVecEnd    = resChunkEnd && (resChunk == BLK_W'(ROW_BLOCKS - 1));

  function automatic laneSel_t nextLane(input laneSel_t cur);
    return (cur == laneSel_t'(NUM_LANES - 1)) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matLane  <= '0;
      matBeat  <= '0;
      matBlock <= '0;
    end else if (evt.matFire) begin
      if (matMatrixEnd) begin
        matBeat  <= '0;
        matBlock <= '0;
        matLane  <= '0;
      end else if (matBlockEnd) begin
        matBeat  <= '0;
        matBlock <= matBlock + 1'b1;
        matLane  <= nextLane(matLane);
      end else begin
        matBeat <= matBeat + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resLane  <= '0;
      resBeat  <= '0;
      resChunk <= '0;
      doneR    <= 1'b0;
    end else begin
      doneR <= evt.resFire && resVecEnd;
      if (evt.resFire) begin
        if (resVecEnd) begin
          resBeat  <= '0;
          resChunk <= '0;
          resLane  <= '0;
        end else if (resChunkEnd) begin
          resBeat  <= '0;
          resChunk <= resChunk + 1'b1;
          resLane  <= nextLane(resLane);
        end else begin
          resBeat <= resBeat + 1'b1;
        end
      end
    end
  end

  assign ctl.matLane = matLane;
  assign ctl.resLane = resLane;
  assign doneOut     = doneR;

  assert_mat_lane_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    matLane < laneSel_t'(NUM_LANES));
  assert_res_lane_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    resLane < laneSel_t'(NUM_LANES));
  assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneR) |-> $past(evt.resFire));
endmodule

// File: rtl/tfr_path.sv
module tfr_path
  import tile_router_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16,
  parameter int RES_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  routeCtl_t                  ctl,
  output routeEvt_t                  evt,
  input  logic [DATA_W-1:0]          vecData,
  input  logic                       vecValid,
  output logic                       vecReady,
  input  logic [DATA_W-1:0]          matData,
  input  logic                       matValid,
  output logic                       matReady,
  output logic [DATA_W-1:0]          laneVecData,
  output logic [NUM_LANES-1:0]       laneVecValid,
  input  logic [NUM_LANES-1:0]       laneVecReady,
  output logic [DATA_W-1:0]          laneMatData,
  output logic [NUM_LANES-1:0]       laneMatValid,
  input  logic [NUM_LANES-1:0]       laneMatReady,
  input  logic [NUM_LANES*RES_W-1:0] laneResData,
  input  logic [NUM_LANES-1:0]       laneResValid,
  output logic [NUM_LANES-1:0]       laneResReady,
  output logic [RES_W-1:0]           resData,
  output logic                       resValid,
  input  logic                       resReady
);
  // lanes that already hold the current broadcast beat
  logic [NUM_LANES-1:0] taken;
  logic                 vecFire;
  logic [NUM_LANES-1:0] matHit, resHit;

  assign laneVecData  = vecData;
  assign laneVecValid = {NUM_LANES{vecValid}} & ~taken;
  assign vecReady     = &(taken | laneVecReady);
  assign vecFire      = vecValid && vecReady;

  always_ff @(posedge clk) begin
    if (!rstN)        taken <= '0;
    else if (vecFire) taken <= '0;
    else              taken <= taken | (laneVecValid & laneVecReady);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : gLane
      assign matHit[g]       = (ctl.matLane == laneSel_t'(g));
      assign resHit[g]       = (ctl.resLane == laneSel_t'(g));
      assign laneMatValid[g] = matValid && matHit[g];
      assign laneResReady[g] = resReady && resHit[g];

      assert_bcast_no_repeat_R3: assert property (@(posedge clk) disable iff (!rstN)
        (laneVecValid[g] && laneVecReady[g] && !vecReady) |=> !laneVecValid[g]);
    end
  endgenerate

  always_comb begin
    matReady = 1'b0;
    resValid = 1'b0;
    resData  = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      matReady = matReady | (matHit[i] & laneMatReady[i]);
      resValid = resValid | (resHit[i] & laneResValid[i]);
      resData  = resData  | ({RES_W{resHit[i]}} & laneResData[i*RES_W +: RES_W]);
    end
  end

  assign laneMatData = matData;
  assign evt.matFire = matValid && matReady;
  assign evt.resFire = resValid && resReady;

  assert_dist_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(laneMatValid));
  assert_join_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(laneResReady));
  assert_bcast_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    vecFire |=> (taken == '0));
endmodule

// File: rtl/tile_fanout_router.sv
module tile_fanout_router
  import tile_router_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CHUNK     = 32,
  parameter int MAT_DIM   = 288,
  parameter int DATA_W    = 16,
  parameter int RES_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DATA_W-1:0]          vecData,
  input  logic                       vecValid,
  output logic                       vecReady,
  input  logic [DATA_W-1:0]          matData,
  input  logic                       matValid,
  output logic                       matReady,
  output logic [DATA_W-1:0]          laneVecData,
  output logic [NUM_LANES-1:0]       laneVecValid,
  input  logic [NUM_LANES-1:0]       laneVecReady,
  output logic [DATA_W-1:0]          laneMatData,
  output logic [NUM_LANES-1:0]       laneMatValid,
  input  logic [NUM_LANES-1:0]       laneMatReady,
  input  logic [NUM_LANES*RES_W-1:0] laneResData,
  input  logic [NUM_LANES-1:0]       laneResValid,
  output logic [NUM_LANES-1:0]       laneResReady,
  output logic [RES_W-1:0]           resData,
  output logic                       resValid,
  input  logic                       resReady,
  output logic                       done
);
  routeCtl_t ctl;
  routeEvt_t evt;

  tfr_ctrl #(.NUM_LANES(NUM_LANES), .CHUNK(CHUNK), .MAT_DIM(MAT_DIM)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .ctl(ctl), .doneOut(done)
  );

  tfr_path #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .RES_W(RES_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evt(evt),
    .vecData(vecData), .vecValid(vecValid), .vecReady(vecReady),
    .matData(matData), .matValid(matValid), .matReady(matReady),
    .laneVecData(laneVecData), .laneVecValid(laneVecValid), .laneVecReady(laneVecReady),
    .laneMatData(laneMatData), .laneMatValid(laneMatValid), .laneMatReady(laneMatReady),
    .laneResData(laneResData), .laneResValid(laneResValid), .laneResReady(laneResReady),
    .resData(resData), .resValid(resValid), .resReady(resReady)
  );
endmodule

// File: tb/tile_fanout_router_tb.sv
`timescale 1ns/1ps
module tile_fanout_router_tb;
  localparam int NL = 3, CH = 4, MD = 16, DW = 16, RW = 32;
  localparam int RB = MD / CH;
  localparam int BB = CH * CH * RB;
  localparam int CYCLES = 2000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [DW-1:0] vecData = '0, matData = '0;
  logic vecValid = 1'b0, matValid = 1'b0, resReady = 1'b0;
  logic vecReady, matReady, resValid, done;
  logic [DW-1:0] laneVecData, laneMatData;
  logic [NL-1:0] laneVecValid, laneMatValid, laneResReady;
  logic [NL-1:0] laneVecReady = '0, laneMatReady = '0, laneResValid = '0;
  logic [NL*RW-1:0] laneResData;
  logic [RW-1:0] resData;

  always #2 clk = ~clk;

  tile_fanout_router #(.NUM_LANES(NL), .CHUNK(CH), .MAT_DIM(MD), .DATA_W(DW), .RES_W(RW)) u_dut (
    .clk(clk), .rstN(rstN), .vecData(vecData), .vecValid(vecValid), .vecReady(vecReady),
    .matData(matData), .matValid(matValid), .matReady(matReady),
    .laneVecData(laneVecData), .laneVecValid(laneVecValid), .laneVecReady(laneVecReady),
    .laneMatData(laneMatData), .laneMatValid(laneMatValid), .laneMatReady(laneMatReady),
    .laneResData(laneResData), .laneResValid(laneResValid), .laneResReady(laneResReady),
    .resData(resData), .resValid(resValid), .resReady(resReady), .done(done)
  );

  int checks = 0, failures = 0;
  int vecIdx = 0, matIdx = 0, outBeats = 0, doneCount = 0;
  int vecGot[NL], resCnt[NL], resExp[NL];
  bit vecFired = 1'b0, matFired = 1'b0, expDone = 1'b0;
  bit resLaneFired[NL];

  generate
    for (genvar gl = 0; gl < NL; gl++) begin : gRes
      assign laneResData[gl*RW +: RW] = {8'(gl), 24'(resCnt[gl])};
    end
  endgenerate

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int laneOfBlock(input int blk);
    return (blk % RB) % NL;
  endfunction

  function automatic bit rnd();
    return ($urandom % 4) != 0;
  endfunction

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int l = 0; l < NL; l++) begin
      vecGot[l] = 0; resCnt[l] = 0; resExp[l] = 0; resLaneFired[l] = 1'b0;
    end
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check(laneVecValid == '0, "R1 laneVecValid", laneVecValid, 0);
    check(laneMatValid == '0, "R1 laneMatValid", laneMatValid, 0);
    check(resValid == 1'b0, "R1 resValid", resValid, 0);
    check(done == 1'b0, "R1 done", done, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      automatic bit full  = (cyc < 150);
      automatic bit stall = (cyc >= 150 && cyc < 180);
      @(negedge clk);
      // drive: valids hold until fired
      if (vecFired || !vecValid) vecValid = full ? 1'b1 : rnd();
      vecData = DW'(vecIdx);
      if (matFired || !matValid) matValid = full ? 1'b1 : rnd();
      matData = DW'(matIdx);
      for (int l = 0; l < NL; l++) begin
        if (resLaneFired[l] || !laneResValid[l]) laneResValid[l] = full ? 1'b1 : rnd();
        laneVecReady[l] = full ? 1'b1 : (stall ? (l != 1) : rnd());
        laneMatReady[l] = full ? 1'b1 : rnd();
      end
      resReady = full ? 1'b1 : rnd();
      #1;
      // done pulse prediction from previous cycle
      check(done == expDone, "R8 done", done, expDone);
      if (done) doneCount++;

      // broadcast
      for (int l = 0; l < NL; l++) begin
        if (vecGot[l] > vecIdx)
          check(!laneVecValid[l], "R3 taken lane not reoffered", laneVecValid[l], 0);
        if (laneVecValid[l] && laneVecReady[l]) begin
          check(laneVecData == DW'(vecGot[l]), "R2 lane vector data", laneVecData, DW'(vecGot[l]));
          vecGot[l]++;
        end
      end
      if (stall && cyc > 152)
        check(!vecReady, "R3 stalled lane blocks beat", vecReady, 0);
      vecFired = vecValid && vecReady;
      if (vecFired) begin
        for (int l = 0; l < NL; l++)
          check(vecGot[l] == vecIdx + 1, "R3 all lanes accepted", vecGot[l], vecIdx + 1);
        vecIdx++;
      end

      // distribution
      begin
        automatic int expLane = laneOfBlock(matIdx / BB);
        if (matValid) begin
          check(laneMatValid == NL'(1 << expLane), ((matIdx / BB) % RB == 0) ? "R5 lane restart" : "R4 lane select",
                laneMatValid, NL'(1 << expLane));
          check(matReady == laneMatReady[expLane], "R6 matReady follows lane", matReady, laneMatReady[expLane]);
        end else begin
          check(laneMatValid == '0, "R6 no lane valid", laneMatValid, 0);
        end
        matFired = matValid && matReady;
        if (matFired) begin
          check(laneMatData == DW'(matIdx), "R4 matrix data", laneMatData, DW'(matIdx));
          matIdx++;
        end
      end

      // join
      begin
        automatic int jl = laneOfBlock(outBeats / CH);
        check(resValid == laneResValid[jl], "R9 resValid from selected lane", resValid, laneResValid[jl]);
        check(laneResReady == (resReady ? NL'(1 << jl) : NL'(0)), "R7 laneResReady", laneResReady,
              resReady ? (1 << jl) : 0);
        for (int l = 0; l < NL; l++) resLaneFired[l] = laneResValid[l] && laneResReady[l];
        expDone = 1'b0;
        if (resValid && resReady) begin
          check(resData == {8'(jl), 24'(resExp[jl])}, "R7 joined data order", resData, {8'(jl), 24'(resExp[jl])});
          resExp[jl]++;
          outBeats++;
          expDone = (outBeats % (RB * CH)) == 0;
        end
      end
      @(posedge clk);
      for (int l = 0; l < NL; l++) if (resLaneFired[l]) resCnt[l]++;
    end

    @(negedge clk);
    #1;
    check(done == expDone, "R8 final done", done, expDone);
    if (done) doneCount++;
    for (int l = 0; l < NL; l++)
      check(vecGot[l] == vecIdx || vecGot[l] == vecIdx + 1, "R2 lane beat count", vecGot[l], vecIdx);
    check(doneCount == outBeats / (RB * CH), "R8 done count", doneCount, outBeats / (RB * CH));
    check(doneCount >= 2, "R8 results completed", doneCount, 2);
    check(matIdx >= 2 * BB * RB, "R5 two matrices routed", matIdx, 2 * BB * RB);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule